// File: doc/BRIEF.md
# System Exception Priority Register Slave

This block sits on a simple single-cycle register bus inside an interrupt controller's system control space. It stores one 8-bit priority for each configurable system exception, twelve entries in the default build. Software may read or write these priorities one byte, two bytes or a whole word at a time. Every accepted priority write raises a one-cycle pulse that tells the priority arbiter to recompute the winning pending exception. The arbiter also reads the whole priority array from a flat output vector.

The block also answers reads from a fixed identification window and from a configuration register that always reads zero. Any other offset accepts only aligned word accesses, which are forwarded to a neighbouring register file through a request strobe and a returned read word. Any illegal access raises the error flag, returns zero and changes nothing.

Top module: `shpr_regslave`

## Requirements
- R1: After reset every priority entry is zero, the update pulse is low and no error is flagged while the bus is idle.
- R2: The priority byte at offset X belongs to exception number X − 0xD14, so offsets 0xD18..0xD23 cover exceptions 4..15. The priority of exception n appears on `prio_flat[8*(n-4)+7 : 8*(n-4)]`.
- R3: The access size is encoded on `bus_size` as 0 = byte, 1 = halfword, 2 = word, 3 = reserved. In the priority window, access byte i refers to offset `bus_addr`+i and travels on data bits [8i+7:8i].
- R4: A priority write changes only the bytes it addresses. All other priority entries keep their values.
- R5: Each accepted priority write drives `prio_upd` high for exactly the one clock cycle that follows it. Back-to-back writes give back-to-back pulses.
- R6: Read data is valid combinationally in the cycle of the access. Bits above the access size are zero, and write cycles return zero.
- R7: Reads of any size in the identification window 0xFE0..0xFFF are legal. An aligned read returns identification word (offset − 0xFE0) >> 2, trimmed to the access size. A read at an offset that is not word-aligned returns zero.
- R8: A write to the identification window raises `bus_err`.
- R9: In the priority window, a halfword at an odd offset, a word not on a 4-byte boundary, or an access that would extend past 0xD23 raises `bus_err`. Such an access returns zero, changes no entry and produces no update pulse.
- R10: An aligned word read of offset 0xD14 returns zero without error. A write there, or a sub-word access there, raises `bus_err`.
- R11: At any other offset, an aligned word access asserts `ext_req` and a read returns `ext_rdata`. A byte, halfword, misaligned or reserved-size access raises `bus_err` with `ext_req` low. The reserved size is an error at every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_addr | input | 12 | Byte offset within the control space |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 reserved) |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Illegal access flag, same cycle |
| ext_req | output | 1 | Forwarded word access to the neighbouring register file |
| ext_rdata | input | 32 | Read data returned for forwarded accesses |
| prio_upd | output | 1 | One-cycle pulse after each priority write |
| prio_flat | output | 96 | All priority entries, exception 4 in the low byte |

## Verification
Two events can overlap in one cycle: the update pulse left by a priority write, and a new priority write or read-back of the same entries. The bench provokes this by issuing writes back to back and by following a write at once with a read of the same word. In every cycle it judges the pulse, the read data and the full priority vector against a model, and the model's entries change only on the clock edge after each write. It also places rejected writes right after accepted ones, to confirm that the pulse still ends and the array stays put.

// File: rtl/shpr_pkg.sv
package shpr_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      RG_IDLE,
      RG_PRIO,
      RG_IDENT,
      RG_CFG,
      RG_FWD
   } region_e;

   typedef struct packed {
      region_e    region;
      logic       err;
      logic [2:0] nbytes;
   } dec_t;

   function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [31:0] trim_lanes(input logic [31:0] d, input logic [2:0] nb);
      logic [31:0] r;
      r = d;
      for (int i = 0; i < 4; i++) begin
         if (i >= int'(nb)) r[8*i +: 8] = 8'h00;
      end
      return r;
   endfunction

endpackage

// File: rtl/shpr_decode.sv
module shpr_decode
   import shpr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int PRIO_BASE = 32'hD18,
   parameter int PRIO_CNT  = 12,
   parameter int CFG_ADDR  = 32'hD14,
   parameter int ID_BASE   = 32'hFE0,
   parameter int ID_WORDS  = 8
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              we,
   output dec_t              dec
);
   localparam int PRIO_END = PRIO_BASE + PRIO_CNT;
   localparam int ID_END   = ID_BASE + 4 * ID_WORDS;

   int         a;
   logic [2:0] nb;
   logic       misal, in_prio, in_id, overrun;

   always_comb begin
      a       = int'(addr);
      nb      = size_to_bytes(size);
      misal   = (size == SZ_HALF && addr[0]) ||
                (size == SZ_WORD && addr[1:0] != 2'b00);
      in_prio = (a >= PRIO_BASE) && (a < PRIO_END);
      in_id   = (a >= ID_BASE) && (a < ID_END);
      overrun = (a + int'(nb)) > PRIO_END;

      dec.nbytes = nb;
      dec.err    = 1'b0;
      dec.region = RG_IDLE;
      if (!sel) begin
         dec.region = RG_IDLE;
      end else if (size == SZ_RSVD) begin
         dec.err = 1'b1;
      end else if (in_prio) begin
         if (misal || overrun) dec.err = 1'b1;
         else                  dec.region = RG_PRIO;
      end else if (in_id) begin
         if (we) dec.err = 1'b1;
         else    dec.region = RG_IDENT;
      end else if (size != SZ_WORD || misal) begin
         dec.err = 1'b1;
      end else if (a == CFG_ADDR) begin
         if (we) dec.err = 1'b1;
         else    dec.region = RG_CFG;
      end else begin
         dec.region = RG_FWD;
      end
   end

endmodule

// File: rtl/shpr_prio_bank.sv
module shpr_prio_bank
   import shpr_pkg::*;
#(
   parameter int PRIO_CNT = 12,
   localparam int OFF_W   = (PRIO_CNT > 1) ? $clog2(PRIO_CNT) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [OFF_W-1:0]      off,
   input  logic [2:0]            nb,
   input  logic [31:0]           wdata,
   output logic [31:0]           rdata,
   output logic [PRIO_CNT*8-1:0] prio_flat,
   output logic                  upd
);
   logic [7:0] ent [PRIO_CNT];

   for (genvar e = 0; e < PRIO_CNT; e++) begin : g_ent
      int         d;
      logic       hit;
      logic [1:0] lane;
      always_comb begin
         d    = e - int'(off);
         hit  = wr && (d >= 0) && (d < int'(nb));
         lane = d[1:0];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)   ent[e] <= 8'h00;
         else if (hit) ent[e] <= wdata[8*lane +: 8];
      end
      assign prio_flat[8*e +: 8] = ent[e];
   end

   always_comb begin
      rdata = 32'h0;
      for (int i = 0; i < 4; i++) begin
         if (i < int'(nb) && (int'(off) + i) < PRIO_CNT)
            rdata[8*i +: 8] = ent[int'(off) + i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) upd <= 1'b0;
      else        upd <= wr;
   end

   // R5
   upd_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> upd);
   // R5
   upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !$past(wr)) |-> 1'b0);
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(prio_flat));

endmodule

// File: rtl/shpr_id_rom.sv
module shpr_id_rom
   import shpr_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int ID_BASE  = 32'hFE0,
   parameter int ID_WORDS = 8,
   parameter logic [ID_WORDS*32-1:0] ID_VALUES = '0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        nb,
   output logic [31:0]       rdata
);
   int rel;
   int wi;

   always_comb begin
      rel   = int'(addr) - ID_BASE;
      wi    = rel >> 2;
      rdata = 32'h0;
      if (rel[1:0] == 2'b00 && wi >= 0 && wi < ID_WORDS)
         rdata = trim_lanes(ID_VALUES[32*wi +: 32], nb);
   end

endmodule

// File: rtl/shpr_regslave.sv
module shpr_regslave
   import shpr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int PRIO_BASE = 32'hD18,
   parameter int PRIO_CNT  = 12,
   parameter int CFG_ADDR  = 32'hD14,
   parameter int ID_BASE   = 32'hFE0,
   parameter int ID_WORDS  = 8,
   parameter logic [ID_WORDS*32-1:0] ID_VALUES = {
      32'h0000_00B1, 32'h0000_000D, 32'h0000_0005, 32'h0000_00F0,
      32'h0000_0000, 32'h0000_000B, 32'h0000_0000, 32'h0000_0000}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [1:0]            bus_size,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   output logic                  bus_err,
   output logic                  ext_req,
   input  logic [31:0]           ext_rdata,
   output logic                  prio_upd,
   output logic [PRIO_CNT*8-1:0] prio_flat
);
   localparam int OFF_W = (PRIO_CNT > 1) ? $clog2(PRIO_CNT) : 1;

   if (PRIO_BASE % 4 != 0) begin : g_bad_base
      $error("priority window must start word aligned");
   end
   if (PRIO_BASE <= CFG_ADDR || PRIO_CNT < 1) begin : g_bad_prio
      $error("priority window must follow the configuration word and be non-empty");
   end
   if (ID_BASE % 4 != 0 || ID_BASE + 4*ID_WORDS > (1 << ADDR_W)) begin : g_bad_id
      $error("identification window misplaced");
   end

   dec_t              dec;
   logic              pw;
   logic [OFF_W-1:0]  poff;
   logic [31:0]       prio_rd, id_rd;

   shpr_decode #(
      .ADDR_W(ADDR_W), .PRIO_BASE(PRIO_BASE), .PRIO_CNT(PRIO_CNT),
      .CFG_ADDR(CFG_ADDR), .ID_BASE(ID_BASE), .ID_WORDS(ID_WORDS)
   ) u_dec (
      .sel(bus_sel), .addr(bus_addr), .size(bus_size), .we(bus_we), .dec(dec)
   );

   assign pw   = (dec.region == RG_PRIO) && bus_we;
   assign poff = OFF_W'(int'(bus_addr) - PRIO_BASE);

   shpr_prio_bank #(.PRIO_CNT(PRIO_CNT)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(pw), .off(poff), .nb(dec.nbytes),
      .wdata(bus_wdata), .rdata(prio_rd), .prio_flat(prio_flat), .upd(prio_upd)
   );

   shpr_id_rom #(
      .ADDR_W(ADDR_W), .ID_BASE(ID_BASE), .ID_WORDS(ID_WORDS), .ID_VALUES(ID_VALUES)
   ) u_id (
      .addr(bus_addr), .nb(dec.nbytes), .rdata(id_rd)
   );

   assign bus_err = dec.err;
   assign ext_req = (dec.region == RG_FWD);

   always_comb begin
      bus_rdata = 32'h0;
      if (!bus_we) begin
         case (dec.region)
            RG_PRIO:  bus_rdata = prio_rd;
            RG_IDENT: bus_rdata = id_rd;
            RG_FWD:   bus_rdata = ext_rdata;
            default:  bus_rdata = 32'h0;
         endcase
      end
   end

   // R9
   err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> $stable(prio_flat));
   // R9
   err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> !prio_upd);
   // R11
   err_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> !ext_req);
   // R6
   byte_rd_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_size == 2'd0) |-> (bus_rdata[31:8] == 24'h0));
   // R7
   id_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && int'(bus_addr) >= ID_BASE &&
       int'(bus_addr) < ID_BASE + 4*ID_WORDS && bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));

endmodule

// File: tb/tb_shpr_regslave.sv
module tb_shpr_regslave;

   localparam logic [255:0] TB_ID = {
      32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 32'hDDEE_FF00,
      32'h0F1E_2D3C, 32'h4B5A_6978, 32'h8796_A5B4, 32'hC3D2_E1F0};
   localparam logic [31:0] EXT_WORD = 32'hCAFE_0123;

   typedef struct packed {
      logic [31:0] rd;
      logic        err;
      logic        ext;
      logic        upd;
      logic [95:0] prio;
      logic [3:0]  req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err, ext_req, prio_upd;
   logic [95:0] prio_flat;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   item_t       q [$];
   logic [7:0]  mdl [12];
   logic        prev_pw = 1'b0;

   always #4 clk = ~clk;

   shpr_regslave #(.ID_VALUES(TB_ID)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .ext_req(ext_req),
      .ext_rdata(EXT_WORD), .prio_upd(prio_upd), .prio_flat(prio_flat)
   );

   function automatic string tag(input logic [3:0] r);
      case (r)
         4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
         4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
         4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
         4'd10: return "R10"; 4'd11: return "R11";
         default: return "R?";
      endcase
   endfunction

   function automatic logic [95:0] flat();
      logic [95:0] f;
      for (int i = 0; i < 12; i++) f[8*i +: 8] = mdl[i];
      return f;
   endfunction

   task automatic check(input string what, input logic [3:0] r,
                        input logic [95:0] act, input logic [95:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag(r), what, act, exp);
      end
   endtask

   // driver: one item per cycle
   task automatic acc(input logic sel, input int a, input int sz, input logic we,
                      input logic [31:0] wd, input logic [3:0] r);
      item_t it;
      int nb;
      logic pw;
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
      it.rd = 32'h0; it.err = 1'b0; it.ext = 1'b0; pw = 1'b0;
      if (sel) begin
         if (sz == 3) it.err = 1'b1;
         else if (a >= 'hD18 && a <= 'hD23) begin
            if ((sz == 1 && a % 2 != 0) || (sz == 2 && a % 4 != 0) || a + nb > 'hD24)
               it.err = 1'b1;
            else if (we) pw = 1'b1;
            else for (int i = 0; i < nb; i++) it.rd[8*i +: 8] = mdl[a - 'hD18 + i];
         end else if (a >= 'hFE0 && a <= 'hFFF) begin
            if (we) it.err = 1'b1;
            else if (a % 4 == 0)
               for (int i = 0; i < nb; i++) it.rd[8*i +: 8] = TB_ID[32*((a - 'hFE0) / 4) + 8*i +: 8];
         end else if (sz != 2 || a % 4 != 0) it.err = 1'b1;
         else if (a == 'hD14) begin
            if (we) it.err = 1'b1;
         end else begin
            it.ext = 1'b1;
            if (!we) it.rd = EXT_WORD;
         end
      end
      @(negedge clk);
      bus_sel = sel; bus_addr = 12'(a); bus_size = 2'(sz); bus_we = we; bus_wdata = wd;
      it.upd = prev_pw; it.prio = flat(); it.req = r;
      q.push_back(it);
      if (pw) for (int i = 0; i < nb; i++) mdl[a - 'hD18 + i] = wd[8*i +: 8];
      prev_pw = pw;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check("rdata", it.req, {64'h0, bus_rdata}, {64'h0, it.rd});
            check("err", it.req, {95'h0, bus_err}, {95'h0, it.err});
            check("ext_req", it.req, {95'h0, ext_req}, {95'h0, it.ext});
            check("prio_upd", (it.upd || prio_upd) ? 4'd5 : it.req, {95'h0, prio_upd}, {95'h0, it.upd});
            check("prio_flat", (it.req == 4'd1) ? 4'd1 : 4'd2, prio_flat, it.prio);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 12; i++) mdl[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, idle bus
      acc(0, 0, 0, 0, 0, 4'd1);
      acc(0, 0, 0, 0, 0, 4'd1);
      // R2 R3 word write to exceptions 4..7, then read-back in the pulse cycle (R5 overlap)
      acc(1, 'hD18, 2, 1, 32'h4433_2211, 4'd3);
      acc(1, 'hD18, 0, 0, 0, 4'd3);
      acc(1, 'hD19, 0, 0, 0, 4'd3);
      acc(1, 'hD1B, 0, 0, 0, 4'd6);
      acc(1, 'hD1A, 1, 0, 0, 4'd3);
      acc(1, 'hD18, 2, 0, 0, 4'd2);
      // R4 single byte into exception 9, neighbours held
      acc(1, 'hD1D, 0, 1, 32'hFFFF_FFAB, 4'd4);
      acc(1, 'hD1C, 2, 0, 0, 4'd4);
      // R3 halfword to exceptions 14,15
      acc(1, 'hD22, 1, 1, 32'h0000_BEEF, 4'd3);
      acc(1, 'hD20, 2, 0, 0, 4'd3);
      // R5 back-to-back writes give consecutive pulses
      acc(1, 'hD20, 0, 1, 32'h0000_0011, 4'd5);
      acc(1, 'hD21, 0, 1, 32'h0000_0022, 4'd5);
      acc(1, 'hD1C, 1, 1, 32'h0000_3344, 4'd5);
      acc(0, 0, 0, 0, 0, 4'd5);
      acc(0, 0, 0, 0, 0, 4'd5);
      // R9 illegal priority accesses right after an accepted write
      acc(1, 'hD18, 0, 1, 32'h0000_0077, 4'd9);
      acc(1, 'hD19, 1, 1, 32'h0000_FFFF, 4'd9);
      acc(1, 'hD1A, 2, 1, 32'hFFFF_FFFF, 4'd9);
      acc(1, 'hD23, 1, 0, 0, 4'd9);
      acc(1, 'hD18, 3, 1, 32'hFFFF_FFFF, 4'd9);
      acc(1, 'hD18, 2, 0, 0, 4'd9);
      acc(1, 'hD20, 2, 0, 0, 4'd9);
      // R7 identification reads
      acc(1, 'hFE0, 2, 0, 0, 4'd7);
      acc(1, 'hFE4, 0, 0, 0, 4'd7);
      acc(1, 'hFE5, 0, 0, 0, 4'd7);
      acc(1, 'hFFC, 1, 0, 0, 4'd7);
      acc(1, 'hFEA, 1, 0, 0, 4'd7);
      acc(1, 'hFF8, 2, 0, 0, 4'd7);
      // R8 identification write
      acc(1, 'hFE8, 2, 1, 32'h1234_5678, 4'd8);
      acc(1, 'hFE0, 2, 0, 0, 4'd8);
      // R10 configuration word
      acc(1, 'hD14, 2, 0, 0, 4'd10);
      acc(1, 'hD14, 2, 1, 32'hFFFF_FFFF, 4'd10);
      acc(1, 'hD14, 0, 0, 0, 4'd10);
      // R11 forwarded and rejected accesses elsewhere
      acc(1, 'h010, 2, 0, 0, 4'd11);
      acc(1, 'h010, 2, 1, 32'hAAAA_5555, 4'd11);
      acc(1, 'h010, 0, 0, 0, 4'd11);
      acc(1, 'h012, 2, 0, 0, 4'd11);
      acc(1, 'hD24, 1, 0, 0, 4'd11);
      acc(1, 'h100, 3, 0, 0, 4'd11);
      // R6 write cycles return zero; final read-back of the whole array
      acc(1, 'hD1C, 2, 1, 32'h0102_0304, 4'd6);
      acc(1, 'hD18, 2, 0, 0, 4'd6);
      acc(1, 'hD1C, 2, 0, 0, 4'd6);
      acc(1, 'hD20, 2, 0, 0, 4'd6);
      acc(0, 0, 0, 0, 0, 4'd5);
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule